// File: doc/BRIEF.md
# Constant-On-Time Buck Gate Sequencer

This block turns a few digital flags from the analog front end of a synchronous buck regulator into two switch enables: one for the high-side transistor and one for the low-side transistor. A high-side pulse of programmed length starts when feedback calls for energy, the valley current is in range, and the forced off interval has run out. The pulse length comes in as a cycle code from outside. Every interval is a cycle count that the parameters derive from the clock period. Dead time separates the two enables in both directions.

The sequencer chooses between two modes. In fixed-frequency mode the low-side switch stays on until the next cycle starts. In light-load pulse-frequency mode the low-side switch is cut at the inductor zero crossing, and each on pulse is stretched to six fifths of the code. The mode follows whether the last switching cycle saw a zero crossing, and it changes only after the new condition has held for a debounce interval. In pulse-frequency mode a long silence on the high side starts a forced cycle. The low side turns on first and discharges the output until feedback asks for energy again. A normal on pulse then follows, with zero-cross truncation as usual. A global disable input drops both enables.

Top module: `cot_sequencer`

## Requirements
- R1: While reset is asserted, and after its release until the first pulse starts, both enables are low and the mode output reads 0 (fixed-frequency mode; 1 means pulse-frequency mode).
- R2: A high-side pulse is requested only in a cycle where `err_hi_i` is 1, `ocp_valley_i` is 0 and the off interval has run out. The high-side enable rises DEAD_CYC+1 cycles after the first such cycle.
- R3: Between two high-side pulses, the high-side enable stays low for at least TOFF_CYC cycles. With `err_hi_i` held at 1 and no over-current, the low time equals TOFF_CYC exactly.
- R4: In fixed-frequency mode, each high-side pulse lasts max(`ton_code_i`, TON_MIN_CYC) cycles.
- R5: In pulse-frequency mode, each high-side pulse lasts max(floor(`ton_code_i`*6/5), TON_MIN_CYC) cycles.
- R6: In pulse-frequency mode, a 1 on `zero_cross_i` while the low side is on drops the low-side enable after one cycle. In fixed-frequency mode the low side stays on regardless, for TOFF_CYC-2*DEAD_CYC cycles per period with `err_hi_i` held.
- R7: The mode takes the value "a zero crossing was seen during the previous low-side interval". It changes only after that value has differed from the current mode for DEB_CYC consecutive cycles. A shorter episode leaves the mode unchanged.
- R8: In pulse-frequency mode, if the high side stays low for ULTRA_CYC cycles, the low-side enable rises in that cycle and stays on until `err_hi_i` is 1. A high-side pulse of normal length then rises DEAD_CYC+1 cycles later.
- R9: The two enables are never high together, and each one rises only after the other has been low for at least DEAD_CYC cycles.
- R10: When `disable_i` is 1 in a cycle, both enables are low from the next cycle on and stay low while it remains 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| disable_i | input | 1 | Global disable; forces both enables low |
| err_hi_i | input | 1 | Error comparator: feedback below reference |
| ocp_valley_i | input | 1 | Valley current above the limit |
| zero_cross_i | input | 1 | Inductor current at or below zero |
| ton_code_i | input | TON_W | Nominal on-time in clock cycles |
| hs_en_o | output | 1 | High-side switch enable |
| ls_en_o | output | 1 | Low-side switch enable |
| pfm_mode_o | output | 1 | 1 in pulse-frequency mode, 0 in fixed-frequency mode |

## Verification
A corrupted state register or interval counter shows at the enables within one switching period. A stray state makes a pulse the wrong length or an off gap the wrong length, breaks the dead-time spacing, or leaves an enable stuck. All of these can be measured to the cycle from the edges of the two enables. A wrong debounce or silence counter appears only at its own horizon: the mode bit changes too early or too late, or the forced low-side pulse rises on the wrong cycle. The bench therefore brackets the mode change with windows on both sides and checks the forced-pulse gap to the exact cycle.

// File: rtl/cot_pkg.sv
package cot_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,  // both switches off, waiting
    ST_DT_PRE  = 3'd1,  // dead time before high side
    ST_ON      = 3'd2,  // high side conducting
    ST_DT_POST = 3'd3,  // dead time after high side
    ST_LS      = 3'd4,  // low side conducting, off interval running
    ST_U_DT    = 3'd5,  // dead time before forced low-side pulse
    ST_U_LS    = 3'd6   // forced low side, waiting for feedback
  } cot_state_e;
endpackage

// File: rtl/cot_ontime.sv
module cot_ontime #(
  parameter int TON_W       = 10,
  parameter int LEN_W       = 13,
  parameter int PFM_NUM     = 6,
  parameter int PFM_DEN     = 5,
  parameter int TON_MIN_CYC = 20
) (
  input  logic [TON_W-1:0] ton_code_i,
  input  logic             pfm_i,
  output logic [LEN_W-1:0] ton_len_o
);
  logic [LEN_W-1:0] base;
  logic [LEN_W-1:0] scaled;

  assign scaled = (LEN_W'(ton_code_i) * LEN_W'(PFM_NUM)) / LEN_W'(PFM_DEN);

  always_comb begin
    base = pfm_i ? scaled : LEN_W'(ton_code_i);
    if (base < LEN_W'(TON_MIN_CYC)) ton_len_o = LEN_W'(TON_MIN_CYC);
    else                            ton_len_o = base;
  end
endmodule

// File: rtl/cot_mode_ctrl.sv
module cot_mode_ctrl #(
  parameter int DEB_CYC = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic zc_i,
  input  logic ls_phase_i,
  input  logic pulse_start_i,
  output logic pfm_o
);
  localparam int DW = $clog2(DEB_CYC + 1);

  logic          seen_q, seen_d, light_q, light_d, pfm_q, pfm_d;
  logic [DW-1:0] deb_q, deb_d;

  always_comb begin
    seen_d  = seen_q;
    light_d = light_q;
    if (pulse_start_i) begin
      light_d = seen_q;
      seen_d  = 1'b0;
    end else if (ls_phase_i && zc_i) begin
      seen_d  = 1'b1;
    end
    pfm_d = pfm_q;
    deb_d = '0;
    if (light_q != pfm_q) begin
      if (deb_q == DW'(DEB_CYC - 1)) pfm_d = light_q;
      else                           deb_d = deb_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      light_q <= 1'b0;
      pfm_q   <= 1'b0;
      deb_q   <= '0;
    end else begin
      seen_q  <= seen_d;
      light_q <= light_d;
      pfm_q   <= pfm_d;
      deb_q   <= deb_d;
    end
  end

  assign pfm_o = pfm_q;
endmodule

// File: rtl/cot_gate_fsm.sv
module cot_gate_fsm
  import cot_pkg::*;
#(
  parameter int DEAD_CYC = 5,
  parameter int OFF_TH   = 64,
  parameter int IDLE_TH  = 7994,
  parameter int LEN_W    = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dis_i,
  input  logic             err_hi_i,
  input  logic             ocp_i,
  input  logic             zc_i,
  input  logic             pfm_i,
  input  logic [LEN_W-1:0] ton_len_i,
  output logic             hs_en_o,
  output logic             ls_en_o,
  output logic             pulse_start_o,
  output logic             ls_phase_o
);
  localparam int OW = $clog2(OFF_TH + 1);
  localparam int IW = $clog2(IDLE_TH + 1);

  cot_state_e       st_q, st_d;
  logic [LEN_W-1:0] cnt_q, cnt_d, ton_q, ton_d;
  logic [OW-1:0]    off_q;
  logic [IW-1:0]    idle_q;
  logic             off_done, idle_done, start_ok, dead_end;
  logic             off_ce, idle_ce;

  assign off_done  = (off_q == OW'(OFF_TH));
  assign idle_done = (idle_q == IW'(IDLE_TH));
  assign start_ok  = err_hi_i && !ocp_i && off_done;
  assign dead_end  = (cnt_q == LEN_W'(DEAD_CYC - 1));

  always_comb begin
    st_d  = st_q;
    ton_d = ton_q;
    unique case (st_q)
      ST_OFF: begin
        if (start_ok)                st_d = ST_DT_PRE;
        else if (pfm_i && idle_done) st_d = ST_U_DT;
      end
      ST_DT_PRE: if (dead_end) begin
        st_d  = ST_ON;
        ton_d = ton_len_i;
      end
      ST_ON:      if (cnt_q == ton_q - 1'b1) st_d = ST_DT_POST;
      ST_DT_POST: if (dead_end) st_d = ST_LS;
      ST_LS: begin
        if (start_ok)          st_d = ST_DT_PRE;
        else if (pfm_i && zc_i) st_d = ST_OFF;
      end
      ST_U_DT: if (dead_end) st_d = ST_U_LS;
      ST_U_LS: if (err_hi_i && !ocp_i) st_d = ST_DT_PRE;
      default: st_d = ST_OFF;
    endcase
    cnt_d = (st_d != st_q) ? '0 : cnt_q + 1'b1;
    if (dis_i) begin
      st_d  = ST_OFF;
      cnt_d = '0;
    end
  end

  assign off_ce  = (st_q == ST_ON) || !off_done;
  assign idle_ce = (st_q == ST_ON) || dis_i || !idle_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OFF;
      cnt_q <= '0;
      ton_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ton_q <= ton_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= '0;
    else if (off_ce) off_q <= (st_q == ST_ON) ? '0 : off_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idle_q <= '0;
    else if (idle_ce) idle_q <= ((st_q == ST_ON) || dis_i) ? '0 : idle_q + 1'b1;
  end

  assign hs_en_o       = (st_q == ST_ON);
  assign ls_en_o       = (st_q == ST_LS) || (st_q == ST_U_LS);
  assign pulse_start_o = (st_q == ST_DT_PRE) && (st_d == ST_ON);
  assign ls_phase_o    = (st_q == ST_LS);
endmodule

// File: rtl/cot_sequencer.sv
module cot_sequencer #(
  parameter int CLK_NS      = 5,
  parameter int TON_W       = 10,
  parameter int TON_MIN_NS  = 100,
  parameter int TOFF_MIN_NS = 350,
  parameter int DEAD_NS     = 25,
  parameter int DEB_NS      = 20000,
  parameter int ULTRA_NS    = 40000,
  parameter int PFM_NUM     = 6,
  parameter int PFM_DEN     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disable_i,
  input  logic             err_hi_i,
  input  logic             ocp_valley_i,
  input  logic             zero_cross_i,
  input  logic [TON_W-1:0] ton_code_i,
  output logic             hs_en_o,
  output logic             ls_en_o,
  output logic             pfm_mode_o
);
  localparam int DEAD_CYC    = (DEAD_NS + CLK_NS - 1) / CLK_NS;
  localparam int TOFF_CYC    = (TOFF_MIN_NS + CLK_NS - 1) / CLK_NS;
  localparam int TON_MIN_CYC = (TON_MIN_NS + CLK_NS - 1) / CLK_NS;
  localparam int DEB_CYC     = (DEB_NS + CLK_NS - 1) / CLK_NS;
  localparam int ULTRA_CYC   = (ULTRA_NS + CLK_NS - 1) / CLK_NS;
  localparam int OFF_TH      = TOFF_CYC - DEAD_CYC - 1;
  localparam int IDLE_TH     = ULTRA_CYC - DEAD_CYC - 1;
  localparam int LEN_W       = TON_W + $clog2(PFM_NUM + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic             pfm, pulse_start, ls_phase;
  logic [LEN_W-1:0] ton_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  cot_ontime #(
    .TON_W(TON_W), .LEN_W(LEN_W), .PFM_NUM(PFM_NUM), .PFM_DEN(PFM_DEN),
    .TON_MIN_CYC(TON_MIN_CYC)
  ) u_ontime (
    .ton_code_i(ton_code_i), .pfm_i(pfm), .ton_len_o(ton_len)
  );

  cot_mode_ctrl #(.DEB_CYC(DEB_CYC)) u_mode (
    .clk(clk), .rst_n(rst_n_int), .zc_i(zero_cross_i), .ls_phase_i(ls_phase),
    .pulse_start_i(pulse_start), .pfm_o(pfm)
  );

  cot_gate_fsm #(
    .DEAD_CYC(DEAD_CYC), .OFF_TH(OFF_TH), .IDLE_TH(IDLE_TH), .LEN_W(LEN_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n_int), .dis_i(disable_i), .err_hi_i(err_hi_i),
    .ocp_i(ocp_valley_i), .zc_i(zero_cross_i), .pfm_i(pfm), .ton_len_i(ton_len),
    .hs_en_o(hs_en_o), .ls_en_o(ls_en_o), .pulse_start_o(pulse_start),
    .ls_phase_o(ls_phase)
  );

  assign pfm_mode_o = pfm;
endmodule

// File: rtl/cot_sequencer_chk.sv
module cot_sequencer_chk #(
  parameter int DEAD_CYC    = 5,
  parameter int TOFF_CYC    = 70,
  parameter int TON_MIN_CYC = 20
) (
  input logic clk,
  input logic rst_n,
  input logic disable_i,
  input logic hs_en_o,
  input logic ls_en_o
);
  logic [15:0] hs_lo_cnt, ls_lo_cnt, hs_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_lo_cnt <= '0;
      ls_lo_cnt <= '0;
      hs_hi_cnt <= '0;
    end else begin
      if (hs_en_o)                hs_lo_cnt <= '0;
      else if (hs_lo_cnt != '1)   hs_lo_cnt <= hs_lo_cnt + 1'b1;
      if (ls_en_o)                ls_lo_cnt <= '0;
      else if (ls_lo_cnt != '1)   ls_lo_cnt <= ls_lo_cnt + 1'b1;
      if (!hs_en_o)               hs_hi_cnt <= '0;
      else if (hs_hi_cnt != '1)   hs_hi_cnt <= hs_hi_cnt + 1'b1;
    end
  end

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en_o && ls_en_o));

  assert_dead_before_hs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en_o) |-> ls_lo_cnt >= 16'(DEAD_CYC));

  assert_dead_before_ls_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en_o) |-> hs_lo_cnt >= 16'(DEAD_CYC));

  assert_min_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en_o) |-> hs_lo_cnt >= 16'(TOFF_CYC));

  assert_min_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hs_en_o) && !$past(disable_i)) |-> hs_hi_cnt >= 16'(TON_MIN_CYC));

  assert_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(disable_i) |-> (!hs_en_o && !ls_en_o));
endmodule

bind cot_sequencer cot_sequencer_chk #(
  .DEAD_CYC(DEAD_CYC), .TOFF_CYC(TOFF_CYC), .TON_MIN_CYC(TON_MIN_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .disable_i(disable_i),
  .hs_en_o(hs_en_o), .ls_en_o(ls_en_o)
);

// File: tb/tb_cot_sequencer.sv
`timescale 1ns/1ps
module tb_cot_sequencer;
  localparam int DEAD = 5, TOFF = 70, TONMIN = 20, ULTRA = 8000;

  logic clk = 1'b0, rst_n = 1'b0, dis = 1'b0, err = 1'b0, ocp = 1'b0, zc = 1'b0;
  logic [9:0] ton = 10'd40;
  logic hs, ls, pfm;

  always #2.5 clk = ~clk;

  cot_sequencer dut (
    .clk(clk), .rst_n(rst_n), .disable_i(dis), .err_hi_i(err), .ocp_valley_i(ocp),
    .zero_cross_i(zc), .ton_code_i(ton), .hs_en_o(hs), .ls_en_o(ls), .pfm_mode_o(pfm)
  );

  int n_chk = 0, n_fail = 0;
  int hs_hi_run = 0, hs_lo_run = 0, ls_hi_run = 0, ls_lo_run = 0;
  int last_hs_hi = 0, last_hs_lo = 0, last_ls_hi = 0, last_ls_gap = 0;
  int hs_rises = 0, ls_rises = 0;
  bit hs_p = 0, ls_p = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  function automatic int exp_len(input int t, input bit p);
    int b;
    b = p ? (t * 6) / 5 : t;
    return (b < TONMIN) ? TONMIN : b;
  endfunction

  // edge monitor: lengths of high and low runs of both enables
  always @(negedge clk) begin
    if (rst_n) begin
      if (hs && ls) chk(1'b0, "R9 enables overlap", 1, 0);
      if (hs && !hs_p) begin
        hs_rises++;
        last_hs_lo = hs_lo_run;
        chk(ls_lo_run >= DEAD, "R9 dead time before high side", ls_lo_run, DEAD);
      end
      if (!hs && hs_p) last_hs_hi = hs_hi_run;
      if (ls && !ls_p) begin
        ls_rises++;
        last_ls_gap = hs_lo_run;
        chk(hs_lo_run >= DEAD, "R9 dead time before low side", hs_lo_run, DEAD);
      end
      if (!ls && ls_p) last_ls_hi = ls_hi_run;
      hs_hi_run = hs ? hs_hi_run + 1 : 0;
      hs_lo_run = hs ? 0 : hs_lo_run + 1;
      ls_hi_run = ls ? ls_hi_run + 1 : 0;
      ls_lo_run = ls ? 0 : ls_lo_run + 1;
      hs_p = hs;
      ls_p = ls;
    end
  end

  task automatic run_ton(input int t, input bit p);
    int e;
    ton = 10'(t);
    e = exp_len(t, p);
    tick(3 * (e + TOFF) + 20);
    if (p) chk(last_hs_hi == e, "R5 pulse-frequency on-time", last_hs_hi, e);
    else   chk(last_hs_hi == e, "R4 fixed-frequency on-time", last_hs_hi, e);
    chk(last_hs_lo == TOFF, "R3 off interval", last_hs_lo, TOFF);
    chk(last_ls_hi == (p ? 1 : TOFF - 2 * DEAD), "R6 low-side length",
        last_ls_hi, p ? 1 : TOFF - 2 * DEAD);
  endtask

  task automatic wait_hs_fall();
    while (!hs) tick(1);
    while (hs) tick(1);
  endtask

  task automatic cycles_to_hs(output int k);
    k = 0;
    while (!hs && k < 1000) begin
      tick(1);
      k++;
    end
  endtask

  initial begin : main
    int tv[10] = '{0, 5, 16, 17, 19, 20, 21, 37, 64, 100};
    int k, r;
    tick(5);
    chk(!hs && !ls && !pfm, "R1 outputs in reset", {hs, ls, pfm}, 0);
    rst_n = 1'b1;
    tick(30);
    chk(!hs && !ls && !pfm, "R1 outputs after release", {hs, ls, pfm}, 0);
    err = 1'b1;

    for (int i = 0; i < 10; i++) run_ton(tv[i], 1'b0);

    // R2: error comparator gating
    ton = 10'd20;
    wait_hs_fall();
    err = 1'b0;
    r = hs_rises;
    tick(300);
    chk(hs_rises == r, "R2 no pulse while error low", hs_rises - r, 0);
    err = 1'b1;
    cycles_to_hs(k);
    chk(k == DEAD + 1, "R2 start latency after error rises", k, DEAD + 1);

    // R2: valley over-current gating
    wait_hs_fall();
    ocp = 1'b1;
    r = hs_rises;
    tick(300);
    chk(hs_rises == r, "R2 no pulse during over-current", hs_rises - r, 0);
    chk(ls == 1'b1, "R2 low side held during over-current", ls, 1);
    ocp = 1'b0;
    cycles_to_hs(k);
    chk(k == DEAD + 1, "R2 start latency after over-current clears", k, DEAD + 1);

    // R10: disable
    while (!hs) tick(1);
    dis = 1'b1;
    tick(1);
    chk(!hs && !ls, "R10 enables low after disable", {hs, ls}, 0);
    r = hs_rises + ls_rises;
    tick(300);
    chk(hs_rises + ls_rises == r, "R10 no enable while disabled", hs_rises + ls_rises - r, 0);
    dis = 1'b0;
    tick(300);

    // R6: fixed-frequency mode ignores zero crossing
    zc = 1'b1;
    tick(300);
    chk(last_ls_hi == TOFF - 2 * DEAD, "R6 no truncation in fixed mode", last_ls_hi, TOFF - 2 * DEAD);
    zc = 1'b0;

    // R7: short light-load episode does not switch
    tick(300);
    zc = 1'b1;
    tick(1500);
    zc = 1'b0;
    tick(5000);
    chk(pfm == 1'b0, "R7 short episode keeps mode", pfm, 0);

    // R7: sustained light load switches after debounce
    zc = 1'b1;
    tick(3900);
    chk(pfm == 1'b0, "R7 mode held before debounce", pfm, 0);
    tick(700);
    chk(pfm == 1'b1, "R7 mode switched to pulse-frequency", pfm, 1);

    for (int i = 0; i < 10; i++) run_ton(tv[i], 1'b1);

    // R8: forced low-side pulse after long silence
    ton = 10'd40;
    tick(300);
    wait_hs_fall();
    err = 1'b0;
    tick(ULTRA + 40);
    chk(last_ls_gap == ULTRA, "R8 forced low side timing", last_ls_gap, ULTRA);
    chk(ls && !hs, "R8 forced low side on", {hs, ls}, 1);
    tick(100);
    chk(ls == 1'b1, "R8 low side held until feedback", ls, 1);
    err = 1'b1;
    cycles_to_hs(k);
    chk(k == DEAD + 1, "R8 on pulse after feedback", k, DEAD + 1);
    tick(exp_len(40, 1'b1) + 10);
    chk(last_hs_hi == exp_len(40, 1'b1), "R8 on-time of forced cycle", last_hs_hi, exp_len(40, 1'b1));

    // R7: back to fixed-frequency mode
    ton = 10'd20;
    zc = 1'b0;
    tick(3900);
    chk(pfm == 1'b1, "R7 mode held before debounce back", pfm, 1);
    tick(700);
    chk(pfm == 1'b0, "R7 mode switched to fixed-frequency", pfm, 0);
    run_ton(30, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule